// File: doc/BRIEF.md
# Overvoltage Restart Supervisor

This block sequences fault recovery for one power-stage output. Comparator flags arrive from the analog side: a warning-level overvoltage, a hard-level overvoltage, a fold-down flag that marks an overcurrent (output sagging below its fold-down threshold) and an overtemperature flag. A register interface supplies one-cycle on/off commands and the choice between automatic restart and latch-on-fault. The block drives the output-enable, a latched-off flag, a one-cycle restarted pulse and a two-bit state code.

All timing is counted in pulses of a `tick` input. Four parameters set the delays in ticks: the warning-level persistence before shutdown, the restart wait, the length of the overvoltage tally window and the minimum off time needed to leave the latched state. At the default values and a 1 ms tick these are 200 ms, 1 s, 60 s and 2 s. A fifth parameter sets how many overvoltage shutdowns inside one window cause a latch.

The output runs only while the run request is active. The run request is the enable pin AND an internal on-command flag. Overvoltage shutdowns in automatic mode are followed by a timed restart. The tally of these shutdowns lives in a window that opens at the first one. When the limit is reached inside the window, the block latches off. Leaving that state needs the run request to be dropped for long enough and then raised again.

Top module: `ovr_supervisor`

## Requirements
- R1: After reset the state code is 0 (running), `latched_off` and `restarted_ok` are low, the on-command flag is set, and `out_en` follows `en_pin`.
- R2: A warning-level overvoltage moves the state code to 1 (delayed shutdown). It shuts the output down only once it has stayed asserted for OV_DLY_TICKS ticks. If it drops earlier, the state code returns to 0 and the output stays on.
- R3: A hard-level overvoltage while running with the run request active shuts the output down at the next clock edge.
- R4: In automatic mode, an overvoltage shutdown that does not reach the limit gives state code 2 (waiting). The output stays off for RESTART_TICKS ticks, then the state code returns to 0.
- R5: The MAX_OV_TRIPS-th overvoltage shutdown inside one window gives state code 3 (latched) instead of a restart.
- R6: The window opens at the first overvoltage shutdown after its last clear. After WINDOW_TICKS ticks it closes and the tally returns to zero, so a later shutdown restarts again.
- R7: `restarted_ok` is high for exactly one cycle, in the cycle the state code returns to 0 from 2 or 3. Leaving state 3 also empties the overvoltage tally.
- R8: The latched state is left only when the run request has been low for at least RELEASE_TICKS ticks and is then raised. Raising it earlier restarts the off-time count from zero.
- R9: `cmd_inhibit` selects latch mode: any overvoltage shutdown, fold-down or overtemperature fault gives state code 3 directly. `cmd_auto` restores automatic restart. If both arrive in the same cycle, `cmd_inhibit` wins.
- R10: The latched state holds while the run request stays active, whatever the fault inputs do afterwards.
- R11: In automatic mode, a fold-down or overtemperature flag while running gives state code 2 and a timed restart. These faults do not add to the overvoltage tally.
- R12: `out_en` is high only in states 0 and 1 with the run request active. `cmd_off` clears the on-command flag and `cmd_on` sets it, with `cmd_off` winning. Fault flags have no effect while the run request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse, one cycle per time unit |
| ov_warn | input | 1 | Warning-level overvoltage comparator |
| ov_hard | input | 1 | Hard-level overvoltage comparator |
| oc_fold | input | 1 | Output below fold-down threshold (overcurrent) |
| ot_hot | input | 1 | Overtemperature fault |
| en_pin | input | 1 | Enable pin, 1 = run allowed |
| cmd_on | input | 1 | One-cycle on command |
| cmd_off | input | 1 | One-cycle off command |
| cmd_inhibit | input | 1 | One-cycle select of latch-on-fault mode |
| cmd_auto | input | 1 | One-cycle select of automatic restart mode |
| out_en | output | 1 | Power stage output enable |
| latched_off | output | 1 | High in the latched state |
| restarted_ok | output | 1 | One-cycle pulse on a successful restart |
| status | output | 2 | 0 running, 1 delayed shutdown, 2 waiting, 3 latched |

## Verification
All state is registered, so the state code, `latched_off` and `restarted_ok` change at the first clock edge after the input or tick that causes the change. A hard overvoltage applied after one edge shows as state 2 or 3 after the next edge. `out_en` also depends directly on `en_pin`, so it changes in the same cycle as that pin. Inputs are driven just after the rising edge, and a behavioural model in the bench advances on that same edge. Outputs are compared against the model on every falling edge. The targeted checks sample one edge after the stimulus, counting tick pulses for the delayed events.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DELAY = 2'd1,
        ST_WAIT  = 2'd2,
        ST_LATCH = 2'd3
    } ovr_state_e;

    typedef struct packed {
        logic ov_warn;
        logic ov_hard;
        logic oc_fold;
        logic ot_hot;
    } ovr_flags_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ovr_cmd_regs.sv
module ovr_cmd_regs (
    input  logic clk,
    input  logic rst,
    input  logic cmd_on,
    input  logic cmd_off,
    input  logic cmd_inhibit,
    input  logic cmd_auto,
    output logic on_q,
    output logic inhibit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            on_q      <= 1'b1;
            inhibit_q <= 1'b0;
        end else begin
            if (cmd_off)      on_q <= 1'b0;
            else if (cmd_on)  on_q <= 1'b1;
            if (cmd_inhibit)   inhibit_q <= 1'b1;
            else if (cmd_auto) inhibit_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ovr_window.sv
module ovr_window #(
    parameter int WINDOW_TICKS = 60000,
    parameter int MAX_OV_TRIPS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trip,
    input  logic clr,
    output logic trip_latches
);
    localparam int WW = $clog2(WINDOW_TICKS + 1);
    localparam int TW = $clog2(MAX_OV_TRIPS + 1);

    logic          act_q;
    logic [WW-1:0] wcnt_q;
    logic [TW-1:0] tries_q;
    logic          expire;
    logic [TW-1:0] tries_e;
    logic          act_e;
    logic [TW:0]   tries_inc;

    always_comb begin
        expire       = act_q && tick && (wcnt_q == WW'(WINDOW_TICKS - 1));
        tries_e      = expire ? '0 : tries_q;
        act_e        = act_q && !expire;
        tries_inc    = {1'b0, tries_e} + 1'b1;
        trip_latches = (tries_inc >= (TW+1)'(MAX_OV_TRIPS));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            act_q   <= 1'b0;
            wcnt_q  <= '0;
            tries_q <= '0;
        end else if (trip) begin
            tries_q <= tries_inc[TW-1:0];
            act_q   <= 1'b1;
            if (!act_e)    wcnt_q <= '0;
            else if (tick) wcnt_q <= wcnt_q + 1'b1;
        end else if (expire) begin
            act_q   <= 1'b0;
            wcnt_q  <= '0;
            tries_q <= '0;
        end else if (act_q && tick) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ovr_fsm.sv
module ovr_fsm
    import ovr_pkg::*;
#(
    parameter int OV_DLY_TICKS  = 200,
    parameter int RESTART_TICKS = 1000,
    parameter int RELEASE_TICKS = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  ovr_flags_t flags,
    input  logic       run_ok,
    input  logic       inhibit,
    input  logic       trip_latches,
    output ovr_state_e state_q,
    output logic       ov_trip,
    output logic       win_clr,
    output logic       rok_q
);
    localparam int TMR_W = $clog2(max_of3(OV_DLY_TICKS, RESTART_TICKS, RELEASE_TICKS) + 1);

    logic [TMR_W-1:0] cnt_q, cnt_n;
    ovr_state_e       st_n;
    logic             rok_n;
    logic             ov_sd;

    always_comb begin
        st_n    = state_q;
        cnt_n   = cnt_q;
        rok_n   = 1'b0;
        ov_sd   = 1'b0;
        ov_trip = 1'b0;
        win_clr = 1'b0;
        case (state_q)
            ST_RUN, ST_DELAY: begin
                if (!run_ok) begin
                    st_n  = ST_RUN;
                    cnt_n = '0;
                end else if (flags.ov_hard) begin
                    ov_sd = 1'b1;
                end else if (flags.oc_fold || flags.ot_hot) begin
                    st_n  = inhibit ? ST_LATCH : ST_WAIT;
                    cnt_n = '0;
                end else if (state_q == ST_RUN) begin
                    if (flags.ov_warn) begin
                        st_n  = ST_DELAY;
                        cnt_n = '0;
                    end
                end else if (!flags.ov_warn) begin
                    st_n  = ST_RUN;
                    cnt_n = '0;
                end else if (tick) begin
                    if (cnt_q == TMR_W'(OV_DLY_TICKS - 1)) ov_sd = 1'b1;
                    else                                   cnt_n = cnt_q + 1'b1;
                end
                if (ov_sd) begin
                    ov_trip = 1'b1;
                    st_n    = (inhibit || trip_latches) ? ST_LATCH : ST_WAIT;
                    cnt_n   = '0;
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (cnt_q == TMR_W'(RESTART_TICKS - 1)) begin
                        st_n  = ST_RUN;
                        cnt_n = '0;
                        rok_n = 1'b1;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                if (run_ok) begin
                    if (cnt_q == TMR_W'(RELEASE_TICKS)) begin
                        st_n    = ST_RUN;
                        rok_n   = 1'b1;
                        win_clr = 1'b1;
                    end
                    cnt_n = '0;
                end else if (tick && cnt_q != TMR_W'(RELEASE_TICKS)) begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            rok_q   <= 1'b0;
        end else begin
            state_q <= st_n;
            cnt_q   <= cnt_n;
            rok_q   <= rok_n;
        end
    end
endmodule

// File: rtl/ovr_supervisor.sv
module ovr_supervisor
    import ovr_pkg::*;
#(
    parameter int OV_DLY_TICKS  = 200,
    parameter int RESTART_TICKS = 1000,
    parameter int WINDOW_TICKS  = 60000,
    parameter int RELEASE_TICKS = 2000,
    parameter int MAX_OV_TRIPS  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ov_warn,
    input  logic       ov_hard,
    input  logic       oc_fold,
    input  logic       ot_hot,
    input  logic       en_pin,
    input  logic       cmd_on,
    input  logic       cmd_off,
    input  logic       cmd_inhibit,
    input  logic       cmd_auto,
    output logic       out_en,
    output logic       latched_off,
    output logic       restarted_ok,
    output logic [1:0] status
);
    logic       on_q, inhibit_q, run_ok;
    logic       trip_latches, ov_trip, win_clr;
    ovr_state_e state_q;
    ovr_flags_t flags;

    assign flags  = '{ov_warn: ov_warn, ov_hard: ov_hard, oc_fold: oc_fold, ot_hot: ot_hot};
    assign run_ok = en_pin && on_q;

    ovr_cmd_regs u_cmd (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .cmd_inhibit(cmd_inhibit), .cmd_auto(cmd_auto),
        .on_q(on_q), .inhibit_q(inhibit_q)
    );

    ovr_window #(.WINDOW_TICKS(WINDOW_TICKS), .MAX_OV_TRIPS(MAX_OV_TRIPS)) u_win (
        .clk(clk), .rst(rst), .tick(tick), .trip(ov_trip), .clr(win_clr),
        .trip_latches(trip_latches)
    );

    ovr_fsm #(
        .OV_DLY_TICKS(OV_DLY_TICKS), .RESTART_TICKS(RESTART_TICKS),
        .RELEASE_TICKS(RELEASE_TICKS)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .flags(flags), .run_ok(run_ok),
        .inhibit(inhibit_q), .trip_latches(trip_latches), .state_q(state_q),
        .ov_trip(ov_trip), .win_clr(win_clr), .rok_q(restarted_ok)
    );

    assign status      = state_q;
    assign latched_off = (state_q == ST_LATCH);
    assign out_en      = run_ok && (state_q == ST_RUN || state_q == ST_DELAY);
endmodule

// File: rtl/ovr_supervisor_chk.sv
module ovr_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       ov_hard,
    input logic       run_ok,
    input logic       restarted_ok,
    input logic [1:0] status
);
    // R3
    ov_hard_chk: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd0 && run_ok && ov_hard) |=> (status == 2'd2 || status == 2'd3));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3 && run_ok) |=> (status == 2'd3 || status == 2'd0));

    // R7
    rok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        restarted_ok |=> !restarted_ok);

    // R7
    rok_src_chk: assert property (@(posedge clk) disable iff (rst)
        restarted_ok |-> (status == 2'd0 && ($past(status) == 2'd2 || $past(status) == 2'd3)));

    // R4
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd2) |=> (status == 2'd2 || status == 2'd0));
endmodule

bind ovr_supervisor ovr_supervisor_chk u_chk (
    .clk(clk), .rst(rst), .ov_hard(ov_hard), .run_ok(run_ok),
    .restarted_ok(restarted_ok), .status(status)
);

// File: tb/ovr_supervisor_bench.sv
module ovr_supervisor_bench;
    localparam int P_OVD = 4;
    localparam int P_RST = 6;
    localparam int P_WIN = 40;
    localparam int P_REL = 8;
    localparam int P_MAX = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic ov_warn = 0, ov_hard = 0, oc_fold = 0, ot_hot = 0;
    logic en_pin = 1, cmd_on = 0, cmd_off = 0, cmd_inhibit = 0, cmd_auto = 0;
    logic out_en, latched_off, restarted_ok;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural reference state
    int m_st = 0, m_cnt = 0, m_on = 1, m_inh = 0, m_rok = 0;
    int m_act = 0, m_wcnt = 0, m_tries = 0;

    always #2 clk = ~clk;

    ovr_supervisor #(
        .OV_DLY_TICKS(P_OVD), .RESTART_TICKS(P_RST), .WINDOW_TICKS(P_WIN),
        .RELEASE_TICKS(P_REL), .MAX_OV_TRIPS(P_MAX)
    ) u_ovr_supervisor (
        .clk(clk), .rst(rst), .tick(tick), .ov_warn(ov_warn), .ov_hard(ov_hard),
        .oc_fold(oc_fold), .ot_hot(ot_hot), .en_pin(en_pin), .cmd_on(cmd_on),
        .cmd_off(cmd_off), .cmd_inhibit(cmd_inhibit), .cmd_auto(cmd_auto),
        .out_en(out_en), .latched_off(latched_off), .restarted_ok(restarted_ok),
        .status(status)
    );

    always @(posedge clk) begin
        #1 tick = rst ? 1'b0 : ~tick;
    end

    // model: advances on each rising edge from the inputs held over the cycle
    always @(posedge clk) begin
        int run, shut, n_st, n_cnt, n_rok, exp_w, tries_now, act_now;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_on = 1; m_inh = 0; m_rok = 0;
            m_act = 0; m_wcnt = 0; m_tries = 0;
        end else begin
            run = (en_pin && m_on) ? 1 : 0;
            shut = 0; n_st = m_st; n_cnt = m_cnt; n_rok = 0;
            exp_w = (m_act == 1 && tick && m_wcnt == P_WIN - 1) ? 1 : 0;
            tries_now = exp_w ? 0 : m_tries;
            act_now = (m_act == 1 && !exp_w) ? 1 : 0;
            if (exp_w) begin m_act = 0; m_wcnt = 0; m_tries = 0; end
            else if (m_act == 1 && tick) m_wcnt++;
            if (m_st <= 1) begin
                if (!run) begin n_st = 0; n_cnt = 0; end
                else if (ov_hard) shut = 1;
                else if (oc_fold || ot_hot) begin n_st = m_inh ? 3 : 2; n_cnt = 0; end
                else if (m_st == 0) begin
                    if (ov_warn) begin n_st = 1; n_cnt = 0; end
                end else if (!ov_warn) begin n_st = 0; n_cnt = 0; end
                else if (tick) begin
                    if (m_cnt + 1 >= P_OVD) shut = 1; else n_cnt = m_cnt + 1;
                end
                if (shut) begin
                    n_cnt = 0;
                    n_st = (m_inh || tries_now + 1 >= P_MAX) ? 3 : 2;
                    if (!act_now) m_wcnt = 0;
                    m_act = 1;
                    m_tries = tries_now + 1;
                end
            end else if (m_st == 2) begin
                if (tick) begin
                    if (m_cnt + 1 >= P_RST) begin n_st = 0; n_cnt = 0; n_rok = 1; end
                    else n_cnt = m_cnt + 1;
                end
            end else begin
                if (run) begin
                    if (m_cnt >= P_REL) begin
                        n_st = 0; n_rok = 1;
                        m_act = 0; m_wcnt = 0; m_tries = 0;
                    end
                    n_cnt = 0;
                end else if (tick && m_cnt < P_REL) n_cnt = m_cnt + 1;
            end
            m_st = n_st; m_cnt = n_cnt; m_rok = n_rok;
            if (cmd_off) m_on = 0; else if (cmd_on) m_on = 1;
            if (cmd_inhibit) m_inh = 1; else if (cmd_auto) m_inh = 0;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(phase, "status", int'(status), m_st);
            chk(phase, "latched_off", int'(latched_off), (m_st == 3) ? 1 : 0);
            chk(phase, "restarted_ok", int'(restarted_ok), m_rok);
            chk(phase, "out_en", int'(out_en), (en_pin && m_on == 1 && m_st <= 1) ? 1 : 0);
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_hard();
        ov_hard = 1; step(1); ov_hard = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 0;
        step(1);
        phase = "R1";
        chk("R1", "reset status", int'(status), 0);
        chk("R1", "reset out_en", int'(out_en), 1);
        chk("R1", "reset latched", int'(latched_off), 0);

        phase = "R2";
        ov_warn = 1; step(5);
        chk("R2", "delayed state", int'(status), 1);
        chk("R2", "out_en in delay", int'(out_en), 1);
        ov_warn = 0; step(2);
        chk("R2", "short warn back to run", int'(status), 0);
        ov_warn = 1; step(12);
        chk("R2", "persisted warn shut down", int'(status), 2);
        ov_warn = 0;

        phase = "R4";
        chk("R4", "out_en off while waiting", int'(out_en), 0);
        step(14);
        chk("R4", "resumed after wait", int'(status), 0);

        phase = "R3";
        pulse_hard();
        chk("R3", "hard ov immediate", int'(status), 2);
        step(14);

        phase = "R5";
        pulse_hard();
        chk("R5", "third trip latches", int'(latched_off), 1);
        phase = "R10";
        ov_warn = 1; oc_fold = 1; step(4); ov_warn = 0; oc_fold = 0;
        step(30);
        chk("R10", "latched holds", int'(status), 3);

        phase = "R8";
        en_pin = 0; step(6); en_pin = 1; step(2);
        chk("R8", "early release stays latched", int'(status), 3);
        en_pin = 0; step(20); en_pin = 1; step(1);
        chk("R8", "released to run", int'(status), 0);
        chk("R7", "restart pulse", int'(restarted_ok), 1);
        step(1);
        phase = "R7";
        chk("R7", "pulse one cycle", int'(restarted_ok), 0);

        phase = "R6";
        pulse_hard(); step(14);
        pulse_hard(); step(100);
        pulse_hard();
        chk("R6", "window expired so restart", int'(status), 2);
        step(14);

        phase = "R11";
        oc_fold = 1; step(1); oc_fold = 0;
        chk("R11", "fold-down waits", int'(status), 2);
        step(14);
        ot_hot = 1; step(1); ot_hot = 0;
        chk("R11", "overtemp waits", int'(status), 2);
        step(14);
        pulse_hard();
        chk("R11", "oc/ot not counted", int'(status), 2);
        step(14);

        phase = "R9";
        cmd_inhibit = 1; cmd_auto = 1; step(1); cmd_inhibit = 0; cmd_auto = 0;
        oc_fold = 1; step(1); oc_fold = 0;
        chk("R9", "inhibit fold-down latches", int'(status), 3);
        phase = "R12";
        cmd_off = 1; cmd_on = 1; step(1); cmd_off = 0; cmd_on = 0;
        step(20);
        chk("R12", "off wins", int'(out_en), 0);
        cmd_on = 1; step(1); cmd_on = 0; step(1);
        chk("R8", "command release", int'(status), 0);
        cmd_off = 1; step(1); cmd_off = 0;
        ov_hard = 1; oc_fold = 1; step(3); ov_hard = 0; oc_fold = 0;
        chk("R12", "faults ignored when off", int'(status), 0);
        chk("R12", "out_en off", int'(out_en), 0);
        cmd_on = 1; step(1); cmd_on = 0; step(1);
        phase = "R9";
        ot_hot = 1; step(1); ot_hot = 0;
        chk("R9", "inhibit overtemp latches", int'(status), 3);
        en_pin = 0; step(20); en_pin = 1; step(2);
        cmd_auto = 1; step(1); cmd_auto = 0;
        pulse_hard();
        chk("R9", "auto restored", int'(status), 2);
        step(14);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule